// File: doc/BRIEF.md
# Millisecond Delay Timer with Preset-Match Interrupt

This block is a delay timer that counts whole milliseconds from a one-cycle tick strobe. It runs either as an on-delay timer, where the done flag rises after the input has been held high for the preset number of ticks, or as an off-delay timer, where the done flag follows the input high and drops the preset number of ticks after the input falls. The mode is chosen by a single select pin.

On top of the ordinary timer, the block can emit a one-cycle interrupt pulse. The pulse appears on the tick update that moves the current value onto the preset. The count stops at the preset, so each timing run gives at most one pulse. A strobe arms interrupt generation and another strobe disarms it. Neither strobe changes the timer itself.

Top module: `match_delay_timer`

## Requirements
- R1: After reset, `count` is 0, `done` is 0, `irq` is 0 and interrupt generation is disarmed.
- R2: `count` increases only on a clock edge where `tick_ms` is 1, and by exactly one at each such step. Apart from that it holds its value or is cleared to 0.
- R3: With `off_mode` = 0 (on-delay), `trig_in` = 0 clears `count` and `done` to 0 at the next edge. While `trig_in` = 1, `count` steps on ticks and `done` is 1 exactly when `count` >= `preset`.
- R4: With `off_mode` = 1 (off-delay), `trig_in` = 1 sets `done` to 1 and clears `count` to 0. After `trig_in` falls, `count` steps on ticks while `done` is 1, and `done` clears on the edge where `count` reaches `preset`.
- R5: `count` never steps past `preset`. Once it has reached the preset it holds there until the input clears it.
- R6: When armed, `irq` is 1 for the single cycle that follows the tick edge that moved `count` onto a nonzero `preset`. It is 0 at all other times.
- R7: `irq_attach` arms and `irq_detach` disarms, each taking effect on the edge at which the strobe is sampled. If both strobes arrive in the same cycle, the detach takes priority.
- R8: The attach and detach strobes have no effect on `count` or `done`.
- R9: A `preset` of 0 never produces an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle millisecond tick strobe |
| trig_in | input | 1 | Timer input / enable |
| off_mode | input | 1 | 0 = on-delay, 1 = off-delay |
| preset | input | W (16) | Preset value in ticks |
| irq_attach | input | 1 | Strobe that arms the match interrupt |
| irq_detach | input | 1 | Strobe that disarms the match interrupt |
| done | output | 1 | Timer done bit |
| count | output | W (16) | Current value |
| irq | output | 1 | One-cycle match interrupt pulse |

## Verification
The key collision happens when an attach or detach strobe lands on the same edge as the tick that moves the count onto the preset. A strobe sampled on that edge decides whether the pulse is emitted. The bench sets this up directly: it arms, then sends attach and detach together on the matching tick, and expects no pulse while the count still reaches the preset. The random phase applies strobes, ticks and input edges independently so that these meetings also occur by chance, and a reference model scores every cycle.

// File: rtl/match_delay_timer.sv
module match_delay_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_ms,
  input  logic         trig_in,
  input  logic         off_mode,
  input  logic [W-1:0] preset,
  input  logic         irq_attach,
  input  logic         irq_detach,
  output logic         done,
  output logic [W-1:0] count,
  output logic         irq
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         done_q, done_d;
  logic         armed_q, arm_now;
  logic         irq_q, irq_d;
  logic         below, step, clear;
  logic [W-1:0] cnt_inc;

  assign below   = cnt_q < preset;
  assign cnt_inc = cnt_q + 1'b1;
  assign clear   = off_mode ? trig_in : ~trig_in;
  assign step    = tick_ms & below & (off_mode ? (~trig_in & done_q) : trig_in);
  assign cnt_d   = clear ? '0 : (step ? cnt_inc : cnt_q);

  always_comb begin
    if (off_mode) done_d = trig_in | (done_q & (cnt_d < preset));
    else          done_d = trig_in & (cnt_d >= preset);
  end

  assign arm_now = (armed_q | irq_attach) & ~irq_detach;
  assign irq_d   = arm_now & step & (cnt_inc == preset) & (preset != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      done_q  <= 1'b0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      armed_q <= arm_now;
      irq_q   <= irq_d;
    end
  end

  assign count = cnt_q;
  assign done  = done_q;
  assign irq   = irq_q;

endmodule

module match_delay_timer_checks #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_ms,
  input logic [W-1:0] preset,
  input logic         irq_detach,
  input logic [W-1:0] count,
  input logic         irq
);

  a_r2_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_ms |=> (count == $past(count) || count == '0));

  a_r5_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= preset) |=> (count <= $past(count)));

  a_r6_irq_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == $past(preset) && count == $past(count) + 1'b1 && $past(tick_ms)));

  a_r7_detach_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_detach |=> !irq);

  a_r9_zero_preset: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(preset) != '0));

endmodule

bind match_delay_timer match_delay_timer_checks #(.W(W)) chk_i (.*);

// File: tb/match_delay_timer_tb_top.sv
`timescale 1ns/1ps
module match_delay_timer_tb_top;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_ms = 0, trig_in = 0, off_mode = 0, irq_attach = 0, irq_detach = 0;
  logic [W-1:0] preset = '0;
  logic done, irq;
  logic [W-1:0] count;

  int n_chk = 0, n_fail = 0, n_irq = 0;
  bit finished = 0;

  logic [W-1:0] m_cnt;
  logic m_done, m_irq, m_arm;

  match_delay_timer #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .trig_in(trig_in),
    .off_mode(off_mode), .preset(preset), .irq_attach(irq_attach),
    .irq_detach(irq_detach), .done(done), .count(count), .irq(irq));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    logic arm, inc;
    if (!rst_n) begin
      m_cnt = '0; m_done = 0; m_irq = 0; m_arm = 0;
    end else begin
      arm = (m_arm | irq_attach) & ~irq_detach;
      inc = 0;
      if (!off_mode) begin
        if (!trig_in) begin m_cnt = '0; m_done = 0; end
        else begin
          if (tick_ms && m_cnt < preset) begin m_cnt = m_cnt + 1'b1; inc = 1; end
          m_done = (m_cnt >= preset);
        end
      end else begin
        if (trig_in) begin m_cnt = '0; m_done = 1; end
        else if (m_done) begin
          if (tick_ms && m_cnt < preset) begin m_cnt = m_cnt + 1'b1; inc = 1; end
          if (m_cnt >= preset) m_done = 0;
        end
      end
      m_irq = arm && inc && (m_cnt == preset) && (preset != '0);
      m_arm = arm;
    end
  end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk(off_mode ? "R4 count" : "R3 count", count, m_cnt);
    chk(off_mode ? "R4 done" : "R3 done", W'(done), W'(m_done));
    chk("R6 irq", W'(irq), W'(m_irq));
    if (irq) n_irq++;
  endtask

  task automatic cyc(bit t, bit tr, bit md, logic [W-1:0] pr, bit at, bit de);
    tick_ms = t; trig_in = tr; off_mode = md; preset = pr; irq_attach = at; irq_detach = de;
    @(negedge clk);
    cmp_model();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int seed_v;
    bit irq_seen;
    seed_v = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk("R1 count", count, '0);
    chk("R1 done", W'(done), '0);
    chk("R1 irq", W'(irq), '0);
    rst_n = 1;
    // R1: disarmed after reset, match must not pulse
    cyc(0, 1, 0, 2, 0, 0);
    irq_seen = 0;
    for (int i = 0; i < 3; i++) begin cyc(1, 1, 0, 2, 0, 0); irq_seen |= irq; end
    chk("R1 disarmed", W'(irq_seen), '0);
    chk("R5 saturate", count, 16'd2);
    cyc(0, 0, 0, 2, 0, 0);
    // R9: zero preset, armed, no pulse
    cyc(0, 0, 0, 0, 1, 0);
    irq_seen = 0;
    for (int i = 0; i < 4; i++) begin cyc(1, 1, 0, 0, 0, 0); irq_seen |= irq; end
    chk("R9 no irq", W'(irq_seen), '0);
    chk("R9 done", W'(done), 1);
    // R7: attach+detach on the matching tick, detach wins; R8 timer unaffected
    cyc(0, 0, 0, 3, 1, 0);
    cyc(1, 1, 0, 3, 0, 0);
    cyc(1, 1, 0, 3, 0, 0);
    cyc(1, 1, 0, 3, 1, 1);
    chk("R7 detach wins", W'(irq), '0);
    chk("R8 count", count, 16'd3);
    chk("R8 done", W'(done), 1);
    // R7: attach on the matching tick arms at once
    cyc(0, 0, 0, 3, 0, 0);
    cyc(1, 1, 0, 3, 0, 0);
    cyc(1, 1, 0, 3, 0, 0);
    cyc(1, 1, 0, 3, 1, 0);
    chk("R7 attach same edge", W'(irq), 1);
    cyc(1, 1, 0, 3, 0, 0);
    chk("R6 single pulse", W'(irq), 0);
    // R4: off-delay run
    cyc(0, 1, 1, 2, 0, 0);
    chk("R4 done high", W'(done), 1);
    cyc(1, 0, 1, 2, 0, 0);
    chk("R4 step", count, 16'd1);
    cyc(0, 0, 1, 2, 0, 0);
    chk("R2 hold", count, 16'd1);
    cyc(1, 0, 1, 2, 0, 0);
    chk("R4 done clear", W'(done), 0);
    chk("R6 off irq", W'(irq), 1);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      bit t, tr, md, at, de;
      logic [W-1:0] pr;
      t  = ($urandom % 3) == 0;
      tr = (($urandom % 12) == 0) ? ~trig_in : trig_in;
      md = (($urandom % 300) == 0) ? ~off_mode : off_mode;
      pr = (($urandom % 80) == 0) ? W'($urandom % 7) : preset;
      at = ($urandom % 25) == 0;
      de = ($urandom % 40) == 0;
      cyc(t, tr, md, pr, at, de);
    end
    chk("R6 pulses seen", W'(n_irq > 2), 1);
    summary();
  end
endmodule